// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block is the transmit half of an I2C bus master. Software queues bytes into a 16-entry transmit queue and steers the transfer through a small control register. When the master-enable bit is set while the bus is idle, the block issues a START condition. It then serializes the queued bytes MSB first on open-drain SCL and SDA pins, and it samples the acknowledge in the ninth clock of every byte. The first byte after any START is the 7-bit device address with the R/W bit, and every byte after it is data.

The block never ends a transfer just because the queue runs dry. Instead it parks the bus with SCL held low and raises an empty flag. From that parked state software has three choices: queue more bytes, request a repeated START, or clear master-enable so that a STOP follows the next byte it queues. A NACK ends the transfer at once, with an error flag and a STOP.

Bytes enter on a valid/ready stream. `tx_ready` is high whenever the queue has room, and a byte is taken on every clock edge where both `tx_valid` and `tx_ready` are high. A byte offered while `tx_ready` is low is discarded and raises the overflow flag. The sender may hold or withdraw `tx_valid` freely. Configuration uses a plain one-cycle write strobe.

Top module: `i2c_tx_master`

## Requirements
- R1: After reset both bus pins are released, `busy` is 0, all three flags are 0, the queue is empty with `tx_ready` 1, and `ctl_state` is 0.
- R2: A write of 1 to enable bit 0 of the control word (cfg_addr 0) while idle produces a START: SDA goes low while SCL is released, and `busy` rises.
- R3: Data bits go out MSB first and are sampled by the receiver on SCL rising. SDA changes only while SCL is low, except at START and STOP.
- R4: The queue is read only while the direction bit (control bit 1) is 1. With direction 0 the controller holds the bus after START and the queued bytes remain in the queue.
- R5: After each byte SDA is released for the ninth clock. A high level there is a NACK: it sets `err_nack`, clears the enable bit, produces a STOP, and returns the block to idle.
- R6: If the queue is empty after START or after an acknowledged byte while enable is 1, SCL stays low and `irq_tx_empty` is set.
- R7: Writing 1 to control bit 2 while the bus is held produces a repeated START. The next queued byte is sent as an address, and bit 2 reads back 0 once the repeated START has been made.
- R8: If enable is 0 and the queue is empty after an acknowledged byte, a STOP follows. Bytes already queued are sent first, and a held bus waits for one more byte before it stops.
- R9: A control write with bit 3 set empties the queue and forces the direction bit to 0.
- R10: The queue holds 16 bytes. `tx_ready` equals not-full, and a byte offered when full is dropped and sets `err_overflow`.
- R11: Each SCL high and low phase lasts D clock cycles, where D is the value at cfg_addr 2 and values below 2 count as 2.
- R12: `busy` stays high from the START until the STOP has completed.
- R13: The flags clear by writing 1 at cfg_addr 1 (bit 0 empty, bit 1 NACK, bit 2 overflow). The empty flag stays set if the bus is still held with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 flag clear, 2 divisor |
| cfg_wdata | input | 8 | Write data |
| tx_valid | input | 1 | Byte offered to the queue |
| tx_data | input | 8 | Byte value |
| tx_ready | output | 1 | Queue has room |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transfer in progress |
| irq_tx_empty | output | 1 | Bus held on empty queue |
| err_nack | output | 1 | NACK seen |
| err_overflow | output | 1 | Byte dropped on full queue |
| fifo_full | output | 1 | Queue full |
| fifo_empty | output | 1 | Queue empty |
| ctl_state | output | 3 | {repeat-start, direction, enable} |

## Verification
Register writes and queue pushes become visible at the port one clock later. The flags follow the condition that sets them one clock after it occurs. Bus events are spread over divisor-sized phases, so the bench does not sample them at fixed cycles. A bus monitor, sampling on the falling clock, records START, byte and STOP events and measures SCL high phases. The bench waits for `busy` or the empty flag with bounded polls and then compares the event log and the flags.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_NEXT, ST_HOLD,
    ST_BLO, ST_BHI, ST_ALO, ST_AHI,
    ST_SLO, ST_SHI, ST_SEND, ST_RLO, ST_RHI
  } eng_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;

  localparam int CTL_EN    = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_RSTA  = 2;
  localparam int CTL_FLUSH = 3;

  localparam int FLG_EMPTY = 0;
  localparam int FLG_NACK  = 1;
  localparam int FLG_OVF   = 2;
endpackage

// File: rtl/i2c_tx_fifo.sv
module i2c_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [AW:0]       count;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R10: the producer never pushes into a full queue
  p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R4: the engine never reads an empty queue
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/i2c_tx_clkdiv.sv
module i2c_tx_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             phase_done
);
  localparam logic [DIV_W-1:0] MIN_PH = DIV_W'(2);

  logic [DIV_W-1:0] cnt, last;

  assign last       = (div < MIN_PH) ? (MIN_PH - 1'b1) : (div - 1'b1);
  assign phase_done = run && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || phase_done) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_tx_engine.sv
module i2c_tx_engine
  import i2c_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_done,
  input  logic              en,
  input  logic              dir,
  input  logic              rsta,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              sda_i,
  output logic              pop,
  output logic              run,
  output logic              scl_low,
  output logic              sda_low,
  output logic              busy,
  output logic              throttled,
  output logic              rsta_done,
  output logic              nack_evt
);
  localparam int BW = $clog2(DATA_W);

  eng_state_e        state, state_n;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bitcnt;
  logic              sent_any;
  logic              sda_q;
  logic              can_send;

  assign can_send  = !fifo_empty && dir;
  assign run       = !(state inside {ST_IDLE, ST_NEXT, ST_HOLD});
  assign scl_low   = state inside {ST_NEXT, ST_HOLD, ST_BLO, ST_ALO, ST_SLO, ST_RLO};
  assign sda_low   = sda_q;
  assign busy      = (state != ST_IDLE);
  assign throttled = (state == ST_HOLD);

  always_comb begin
    state_n   = state;
    pop       = 1'b0;
    rsta_done = 1'b0;
    nack_evt  = 1'b0;
    unique case (state)
      ST_IDLE:  if (en) state_n = ST_START;
      ST_START: if (phase_done) state_n = ST_NEXT;
      ST_NEXT: begin
        if (can_send) begin
          pop     = 1'b1;
          state_n = ST_BLO;
        end else if (!en && sent_any) begin
          state_n = ST_SLO;
        end else begin
          state_n = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (can_send) begin
          pop     = 1'b1;
          state_n = ST_BLO;
        end else if (rsta && sent_any) begin
          state_n = ST_RLO;
        end
      end
      ST_BLO: if (phase_done) state_n = ST_BHI;
      ST_BHI: if (phase_done) state_n = (bitcnt == '0) ? ST_ALO : ST_BLO;
      ST_ALO: if (phase_done) state_n = ST_AHI;
      ST_AHI: begin
        if (phase_done) begin
          if (sda_i) begin
            nack_evt = 1'b1;
            state_n  = ST_SLO;
          end else begin
            state_n = ST_NEXT;
          end
        end
      end
      ST_SLO:  if (phase_done) state_n = ST_SHI;
      ST_SHI:  if (phase_done) state_n = ST_SEND;
      ST_SEND: if (phase_done) state_n = ST_IDLE;
      ST_RLO:  if (phase_done) state_n = ST_RHI;
      ST_RHI: begin
        if (phase_done) begin
          rsta_done = 1'b1;
          state_n   = ST_START;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      sent_any <= 1'b0;
      sda_q    <= 1'b0;
    end else begin
      state <= state_n;
      if (pop) begin
        shreg  <= fifo_data;
        bitcnt <= BW'(DATA_W - 1);
      end else if (state == ST_BHI && phase_done && bitcnt != '0) begin
        shreg  <= shreg << 1;
        bitcnt <= bitcnt - 1'b1;
      end
      if (state == ST_START) sent_any <= 1'b0;
      else if (pop)          sent_any <= 1'b1;
      unique case (state)
        ST_IDLE, ST_ALO, ST_RLO, ST_SEND: sda_q <= 1'b0;
        ST_START, ST_SLO:                 sda_q <= 1'b1;
        ST_BLO:                           sda_q <= ~shreg[DATA_W-1];
        default:                          sda_q <= sda_q;
      endcase
    end
  end

  // R3: SDA moves only inside a low SCL phase, apart from START and STOP
  p_sda_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_q != $past(sda_q)) |->
      ((scl_low && $past(scl_low)) || state == ST_START || state == ST_SEND));
endmodule

// File: rtl/i2c_tx_master.sv
module i2c_tx_master
  import i2c_tx_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  DIV_RESET  = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              busy,
  output logic              irq_tx_empty,
  output logic              err_nack,
  output logic              err_overflow,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [2:0]        ctl_state
);
  logic              ctl_en, ctl_dir, ctl_rsta;
  logic [DATA_W-1:0] div_q;
  logic              ctrl_wr, flag_wr, div_wr, flush;
  logic              push, pop, run, phase_done;
  logic              throttled, rsta_done, nack_evt;
  logic [DATA_W-1:0] fifo_rdata;

  assign ctrl_wr   = cfg_we && (cfg_addr == ADDR_CTRL);
  assign flag_wr   = cfg_we && (cfg_addr == ADDR_FLAG);
  assign div_wr    = cfg_we && (cfg_addr == ADDR_DIV);
  assign flush     = ctrl_wr && cfg_wdata[CTL_FLUSH];
  assign tx_ready  = !fifo_full;
  assign push      = tx_valid && tx_ready;
  assign ctl_state = {ctl_rsta, ctl_dir, ctl_en};

  i2c_tx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .wdata(tx_data),
    .pop(pop), .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
  );

  i2c_tx_clkdiv #(.DIV_W(DATA_W)) div_i (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .phase_done(phase_done)
  );

  i2c_tx_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .phase_done(phase_done),
    .en(ctl_en), .dir(ctl_dir), .rsta(ctl_rsta),
    .fifo_empty(fifo_empty), .fifo_data(fifo_rdata), .sda_i(sda_i),
    .pop(pop), .run(run), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .busy(busy), .throttled(throttled), .rsta_done(rsta_done), .nack_evt(nack_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_dir  <= 1'b0;
      ctl_rsta <= 1'b0;
      div_q    <= DIV_RESET;
    end else begin
      if (ctrl_wr) begin
        ctl_en   <= cfg_wdata[CTL_EN];
        ctl_dir  <= cfg_wdata[CTL_DIR] && !cfg_wdata[CTL_FLUSH];
        ctl_rsta <= cfg_wdata[CTL_RSTA];
      end else begin
        if (nack_evt)  ctl_en   <= 1'b0;
        if (rsta_done) ctl_rsta <= 1'b0;
      end
      if (div_wr) div_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx_empty <= 1'b0;
      err_nack     <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      irq_tx_empty <= (throttled && fifo_empty) ||
                      (irq_tx_empty && !(flag_wr && cfg_wdata[FLG_EMPTY]));
      err_nack     <= nack_evt ||
                      (err_nack && !(flag_wr && cfg_wdata[FLG_NACK]));
      err_overflow <= (tx_valid && fifo_full) ||
                      (err_overflow && !(flag_wr && cfg_wdata[FLG_OVF]));
    end
  end

  // R5: a NACK withdraws the enable bit
  p_nack_drops_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_evt && !ctrl_wr) |=> !ctl_en);
  // R7: the repeat-start request clears itself once made
  p_rsta_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsta_done && !ctrl_wr) |=> !ctl_rsta);
  // R6: a held bus with nothing queued raises the empty flag
  p_empty_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (throttled && fifo_empty) |=> irq_tx_empty);
  // R10: a byte offered to a full queue is flagged
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && fifo_full) |=> err_overflow);
endmodule

// File: tb/i2c_tx_master_tb_top.sv
`timescale 1ns/1ps
module i2c_tx_master_tb_top;
  localparam int EV_START = 256;
  localparam int EV_STOP  = 512;
  // fields: [31:24] seed, [23:16] address, [15:12] divisor, [8] mode,
  //         [7:4] NACK byte index (F = none), [3:0] byte count
  localparam logic [31:0] VEC [0:5] = '{
    32'h55A0_20F3, 32'h003C_11F5, 32'hFFFE_40F2,
    32'h8152_2124, 32'h00C4_01F1, 32'h1190_3106
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready, scl_drive_low, sda_drive_low, busy;
  logic       irq_tx_empty, err_nack, err_overflow, fifo_full, fifo_empty;
  logic [2:0] ctl_state;
  logic       ack_drv = 1'b0;
  logic       scl_l, sda_l;

  int checks = 0;
  int errors = 0;
  int nack_idx = 99;
  int log_mem [256];
  int log_n = 0;
  int hi_cnt = 0, hi_len = 0;
  int bitcnt = 0, byte_idx = 0;
  logic [7:0] sh = '0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  int exp_a [32];
  int exp_n;

  always #2.5 clk = ~clk;

  assign scl_l = !scl_drive_low;
  assign sda_l = !(sda_drive_low || ack_drv);

  i2c_tx_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .sda_i(sda_l), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .busy(busy), .irq_tx_empty(irq_tx_empty),
    .err_nack(err_nack), .err_overflow(err_overflow), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .ctl_state(ctl_state)
  );

  // bus monitor and acknowledging receiver
  always @(negedge clk) begin
    logic s, d;
    s = scl_l;
    d = sda_l;
    if (rst_n) begin
      if (scl_p && s && sda_p && !d) begin
        log_mem[log_n] = EV_START; log_n++; bitcnt = 0; byte_idx = 0;
      end else if (scl_p && s && !sda_p && d) begin
        log_mem[log_n] = EV_STOP; log_n++; bitcnt = 0;
      end else if (!scl_p && s) begin
        hi_cnt = 1;
        if (bitcnt < 8) begin
          sh = {sh[6:0], d};
          bitcnt++;
          if (bitcnt == 8) begin log_mem[log_n] = int'(sh); log_n++; end
        end else begin
          bitcnt = 0; byte_idx++;
        end
      end else if (scl_p && s) begin
        hi_cnt++;
      end else if (scl_p && !s) begin
        hi_len = hi_cnt;
        if (ack_drv) ack_drv = 1'b0;
        else if (bitcnt == 8) ack_drv = (byte_idx != nack_idx);
      end
    end
    scl_p = s;
    sda_p = d;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = v;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, req, int'(busy), 0);
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq_tx_empty && n < 5000) begin @(negedge clk); n++; end
    chk(irq_tx_empty, req, int'(irq_tx_empty), 1);
  endtask

  task automatic cmp_log(input int base, input string req);
    chk(log_n - base == exp_n, req, log_n - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (base + i < log_n)
        chk(log_mem[base + i] == exp_a[i], req, log_mem[base + i], exp_a[i]);
  endtask

  function automatic logic [7:0] vbyte(input logic [31:0] v, input int i);
    if (i == 0) return v[23:16];
    return 8'(int'(v[31:24]) + i * 8'h17);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(!scl_drive_low && !sda_drive_low, "R1 bus", {scl_drive_low, sda_drive_low}, 0);
    chk(!busy && !irq_tx_empty && !err_nack && !err_overflow, "R1 flags",
        {busy, irq_tx_empty, err_nack, err_overflow}, 0);
    chk(fifo_empty && tx_ready && !fifo_full, "R1 queue", {fifo_empty, tx_ready, fifo_full}, 6);
    chk(ctl_state == 3'b000, "R1 ctl", ctl_state, 0);

    // table walk: R2 R3 R4 R5 R8 R11 R12
    for (int v = 0; v < 6; v++) begin
      int n, nk, dv, base, last;
      bit nacked;
      n  = int'(VEC[v][3:0]);
      nk = (VEC[v][7:4] == 4'hF) ? 99 : int'(VEC[v][7:4]);
      dv = int'(VEC[v][15:12]);
      nacked = (nk < n);
      wr(2'd0, 8'h08);
      wr(2'd1, 8'h07);
      wr(2'd2, 8'(dv));
      nack_idx = nk;
      base = log_n;
      if (!VEC[v][8]) begin
        for (int i = 0; i < n - 1; i++) push(vbyte(VEC[v], i));
        wr(2'd0, 8'h03);
        wait_irq("R6 throttle flag");
        chk(scl_drive_low, "R6 scl held", int'(scl_drive_low), 1);
        chk(busy, "R12 busy during", int'(busy), 1);
        wr(2'd0, 8'h02);
        push(vbyte(VEC[v], n - 1));
      end else begin
        for (int i = 0; i < n; i++) push(vbyte(VEC[v], i));
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h02);
      end
      wait_idle("R12 busy ends");
      last = nacked ? nk : n - 1;
      exp_n = 0;
      exp_a[exp_n++] = EV_START;
      for (int i = 0; i <= last; i++) exp_a[exp_n++] = int'(vbyte(VEC[v], i));
      exp_a[exp_n++] = EV_STOP;
      cmp_log(base, nacked ? "R5 nack log" : "R8 transfer log");
      chk(err_nack == nacked, "R5 nack flag", int'(err_nack), int'(nacked));
      chk(ctl_state[0] == 1'b0, "R5 enable off", int'(ctl_state[0]), 0);
      chk(hi_len == ((dv < 2) ? 2 : dv), "R11 scl high", hi_len, (dv < 2) ? 2 : dv);
    end
    nack_idx = 99;

    // R13: NACK flag clears by write-one
    wr(2'd1, 8'h02);
    @(negedge clk);
    chk(!err_nack, "R13 nack clear", int'(err_nack), 0);

    // R7: repeated start from the held bus
    begin
      int base;
      wr(2'd0, 8'h08);
      wr(2'd1, 8'h07);
      wr(2'd2, 8'd2);
      base = log_n;
      push(8'h42); push(8'h99);
      wr(2'd0, 8'h03);
      wait_irq("R6 held");
      wr(2'd1, 8'h01);
      @(negedge clk);
      chk(irq_tx_empty, "R13 empty resets", int'(irq_tx_empty), 1);
      wr(2'd0, 8'h07);
      chk(ctl_state[2], "R7 request set", int'(ctl_state[2]), 1);
      begin
        int n = 0;
        while (ctl_state[2] && n < 2000) begin @(negedge clk); n++; end
      end
      chk(!ctl_state[2], "R7 self clear", int'(ctl_state[2]), 0);
      wr(2'd1, 8'h01);
      wait_irq("R7 held again");
      push(8'hA7);
      repeat (4) @(negedge clk);
      wr(2'd1, 8'h01);
      wait_irq("R6 after address");
      wr(2'd0, 8'h02);
      push(8'h5A);
      wait_idle("R12 rsta end");
      exp_n = 0;
      exp_a[exp_n++] = EV_START; exp_a[exp_n++] = 8'h42; exp_a[exp_n++] = 8'h99;
      exp_a[exp_n++] = EV_START; exp_a[exp_n++] = 8'hA7; exp_a[exp_n++] = 8'h5A;
      exp_a[exp_n++] = EV_STOP;
      cmp_log(base, "R7 rsta log");
      wr(2'd1, 8'h01);
      @(negedge clk);
      chk(!irq_tx_empty, "R13 empty clear idle", int'(irq_tx_empty), 0);
    end

    // R4: direction 0 keeps bytes queued
    begin
      int base;
      wr(2'd0, 8'h08);
      base = log_n;
      push(8'h66);
      wr(2'd0, 8'h01);
      repeat (60) @(negedge clk);
      chk(!fifo_empty, "R4 byte kept", int'(fifo_empty), 0);
      chk(log_n - base == 1 && log_mem[base] == EV_START, "R4 only start",
          log_n - base, 1);
      chk(scl_drive_low, "R4 bus held", int'(scl_drive_low), 1);
      wr(2'd0, 8'h03);
      wr(2'd0, 8'h02);
      wait_idle("R8 dir end");
      exp_n = 0;
      exp_a[exp_n++] = EV_START; exp_a[exp_n++] = 8'h66; exp_a[exp_n++] = EV_STOP;
      cmp_log(base, "R4 dir log");
    end

    // R9: queue reset clears direction
    wr(2'd0, 8'h02);
    push(8'h11); push(8'h22);
    chk(!fifo_empty && ctl_state[1], "R9 before", {fifo_empty, ctl_state[1]}, 1);
    wr(2'd0, 8'h0A);
    chk(fifo_empty, "R9 emptied", int'(fifo_empty), 1);
    chk(!ctl_state[1], "R9 dir cleared", int'(ctl_state[1]), 0);

    // R10: overflow
    wr(2'd1, 8'h07);
    for (int i = 0; i < 16; i++) push(8'(i));
    chk(fifo_full && !tx_ready, "R10 full", {fifo_full, tx_ready}, 2);
    chk(!err_overflow, "R10 no flag yet", int'(err_overflow), 0);
    push(8'hEE);
    chk(err_overflow, "R10 overflow", int'(err_overflow), 1);
    wr(2'd1, 8'h04);
    @(negedge clk);
    chk(!err_overflow, "R13 overflow clear", int'(err_overflow), 0);
    wr(2'd0, 8'h08);
    chk(fifo_empty && tx_ready, "R9 after full", {fifo_empty, tx_ready}, 3);

    summary();
    $finish;
  end
endmodule